// File: doc/BRIEF.md
# Debug-hold warm reset override

This block watches an active-low warm-reset line that an external debug agent can hold low. While the processor supply is up, a hold on that line makes the block take over two lines of the processor's power handshake. It drives the processor reset line low so the processor stays held. It drives the power keep-alive line high so the power-management IC still sees a healthy, running processor. When the agent lets go of the line, the block issues a one-cycle request for a full cold power cycle to the surrounding sequencer.

The block keeps driving both lines after the hold ends. It stops only when the supply-good indication falls, which happens when the cold power cycle takes the rail down. Both lines then go back to high impedance. A fall of the warm-reset line while the supply is already down is treated as the line's pull-up rail collapsing, and the block ignores it.

Both inputs must already be synchronised to the block clock. The block detects edges with one register stage per input. The pad voltage selection and the power sequencing itself are handled elsewhere.

Top module: `warm_hold_override`

## Requirements
- R1: A synchronous active-low reset clears the takeover state. After any clock edge with reset low, `takeover_o`, `cold_req_o`, both enables are 0, `cpu_rst_lvl_o` is 1 and `keepalive_lvl_o` is 0.
- R2: When `hold_n_i` is 1 in one cycle and 0 in the next while `rail_ok_i` is 1, the outputs change at the following clock edge. `takeover_o` becomes 1, both enables become 1, `cpu_rst_lvl_o` becomes 0 and `keepalive_lvl_o` becomes 1.
- R3: A 1-to-0 change of `hold_n_i` while `rail_ok_i` is 0 does not start a takeover. A later rise of `rail_ok_i` while the hold is still low does not start one either.
- R4: A 0-to-1 change of `hold_n_i` while `takeover_o` is 1 makes `cold_req_o` 1 for exactly one cycle, after the next edge. Both drives stay enabled.
- R5: A 0-to-1 change of `hold_n_i` while `takeover_o` is 0 never raises `cold_req_o`.
- R6: A 1-to-0 change of `rail_ok_i` while `takeover_o` is 1 clears `takeover_o` and both enables at the next edge. Both lines then go back to high impedance.
- R7: Changes of `rail_ok_i` while `takeover_o` is 0 have no effect on any output.
- R8: Both enables always equal `takeover_o`. When the lines are not driven, the level outputs rest at their released values: reset level 1 and keep-alive level 0.
- R9: If `hold_n_i` is already 0 on the first edge after reset is released and `rail_ok_i` is 1, this counts as a fall, and the takeover follows at that edge.
- R10: If a 0-to-1 change of `hold_n_i` and a 1-to-0 change of `rail_ok_i` arrive in the same cycle during a takeover, the block both pulses `cold_req_o` and releases the drives at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_n_i | input | 1 | Synchronised warm-reset line, low while held |
| rail_ok_i | input | 1 | Synchronised supply-good indication |
| cpu_rst_oe_o | output | 1 | Output enable for the processor reset line |
| cpu_rst_lvl_o | output | 1 | Level for the processor reset line |
| keepalive_oe_o | output | 1 | Output enable for the power keep-alive line |
| keepalive_lvl_o | output | 1 | Level for the power keep-alive line |
| takeover_o | output | 1 | High while the block overdrives both lines |
| cold_req_o | output | 1 | One-cycle request for a cold power cycle |

## Verification
The assertions assume that both inputs are clean, synchronised levels that change only between clock edges. They also assume that a hold is always preceded by at least one cycle in which the line is high, because an edge exists only as a difference between consecutive samples. The stimulus changes inputs only on the falling clock edge and keeps every level for at least one full cycle. The scenarios cover a hold under a live rail, a hold under a dead rail, a release and a rail collapse in the same cycle, and a hold present as reset is released.

// File: rtl/wro_pkg.sv
// Package: shared definitions for the debug-hold warm reset override.
// Assumes the two overdriven lines are always indexed as declared here.
package wro_pkg;
    // Number of lines the block can overdrive
    localparam int LINE_CNT      = 2;
    // Index of the processor reset line
    localparam int IDX_CPU_RST   = 0;
    // Index of the power keep-alive line
    localparam int IDX_KEEPALIVE = 1;
    // Level each line takes while driven (reset low, keep-alive high)
    localparam logic [LINE_CNT-1:0] DRIVE_LVL = 2'b10;

    // Edge detector channel positions
    localparam int CH_HOLD  = 0;
    localparam int CH_RAIL  = 1;
    localparam int CH_CNT   = 2;
    // Edge detector reset history: hold idles high, rail assumed down
    localparam logic [CH_CNT-1:0] CH_RST_VAL = 2'b01;

    // Tri-state drive of one line
    typedef struct packed {
        logic oe;
        logic lvl;
    } line_drive_t;
endpackage

// File: rtl/wro_edge.sv
// Module: per-channel edge detector.
// Keeps one cycle of history per channel and flags rises and falls as
// combinational pulses valid for the cycle in which the new level shows.
// Assumes inputs are already synchronised to clk.
module wro_edge #(
    parameter int                 WIDTH   = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_ch
        // Purpose: hold the previous sample of channel i
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= RST_VAL[i];
            else        prev_q[i] <= din[i];
        end
        assign rise[i] = ~prev_q[i] &  din[i];
        assign fall[i] =  prev_q[i] & ~din[i];
    end
endmodule

// File: rtl/wro_core.sv
// Module: takeover flag and cold-reset request generator.
// The flag is set by a hold fall while the rail is up and cleared only by
// a rail collapse. The request pulses once per hold release seen during
// a takeover. Assumes the edge strobes are single-cycle.
module wro_core (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_fall,
    input  logic hold_rise,
    input  logic rail_ok,
    input  logic rail_fall,
    output logic flag_o,
    output logic req_o
);
    logic flag_q;
    logic req_q;

    // Purpose: track whether the block is overdriving the lines
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (flag_q && rail_fall)  flag_q <= 1'b0;
        else if (hold_fall && rail_ok) flag_q <= 1'b1;
    end

    // Purpose: one-cycle cold power cycle request on release during takeover
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= hold_rise & flag_q;
    end

    assign flag_o = flag_q;
    assign req_o  = req_q;
endmodule

// File: rtl/wro_pads.sv
// Module: maps the takeover flag onto tri-state drives.
// Each line is enabled while the flag is set and then takes its DRIVE_LVL
// bit; when released, its level rests at the opposite value.
module wro_pads
    import wro_pkg::*;
#(
    parameter int                N         = LINE_CNT,
    parameter logic [N-1:0]      DRIVE_VAL = DRIVE_LVL
) (
    input  logic                  takeover,
    output line_drive_t [N-1:0]   lines_o
);
    for (genvar i = 0; i < N; i++) begin : g_line
        // Purpose: enable and level of line i
        always_comb begin
            lines_o[i].oe  = takeover;
            lines_o[i].lvl = takeover ? DRIVE_VAL[i] : ~DRIVE_VAL[i];
        end
    end
endmodule

// File: rtl/warm_hold_override.sv
// Module: top of the debug-hold warm reset override.
// Overdrives the processor reset (low) and power keep-alive (high) while
// an external agent holds the warm-reset line under a live rail. It then
// requests a cold cycle on release and lets go when the rail collapses.
// Assumes hold_n_i and rail_ok_i are synchronised to clk.
module warm_hold_override
    import wro_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n_i,
    input  logic rail_ok_i,
    output logic cpu_rst_oe_o,
    output logic cpu_rst_lvl_o,
    output logic keepalive_oe_o,
    output logic keepalive_lvl_o,
    output logic takeover_o,
    output logic cold_req_o
);
    logic [CH_CNT-1:0]          ch_in;
    logic [CH_CNT-1:0]          ch_rise;
    logic [CH_CNT-1:0]          ch_fall;
    logic                       flag;
    line_drive_t [LINE_CNT-1:0] lines;

    assign ch_in[CH_HOLD] = hold_n_i;
    assign ch_in[CH_RAIL] = rail_ok_i;

    wro_edge #(
        .WIDTH   (CH_CNT),
        .RST_VAL (CH_RST_VAL)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ch_in),
        .rise (ch_rise),
        .fall (ch_fall)
    );

    wro_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_fall(ch_fall[CH_HOLD]),
        .hold_rise(ch_rise[CH_HOLD]),
        .rail_ok  (rail_ok_i),
        .rail_fall(ch_fall[CH_RAIL]),
        .flag_o   (flag),
        .req_o    (cold_req_o)
    );

    wro_pads #(
        .N        (LINE_CNT),
        .DRIVE_VAL(DRIVE_LVL)
    ) u_pads (
        .takeover(flag),
        .lines_o (lines)
    );

    assign takeover_o      = flag;
    assign cpu_rst_oe_o    = lines[IDX_CPU_RST].oe;
    assign cpu_rst_lvl_o   = lines[IDX_CPU_RST].lvl;
    assign keepalive_oe_o  = lines[IDX_KEEPALIVE].oe;
    assign keepalive_lvl_o = lines[IDX_KEEPALIVE].lvl;
endmodule

// File: rtl/warm_hold_override_chk.sv
// Module: property checker for warm_hold_override, bound to the top.
// Observes ports only.
module warm_hold_override_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_n_i,
    input logic rail_ok_i,
    input logic cpu_rst_oe_o,
    input logic keepalive_oe_o,
    input logic takeover_o,
    input logic cold_req_o
);
    AST_TAKEOVER_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold_n_i) && !hold_n_i && rail_ok_i) |=> takeover_o); // R2

    AST_NO_TAKEOVER_DEAD_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (!takeover_o && !rail_ok_i) |=> !takeover_o); // R3

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cold_req_o |=> !cold_req_o); // R4

    AST_REQ_NEEDS_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
        cold_req_o |-> $past(takeover_o)); // R5

    AST_RELEASE_ON_RAIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (takeover_o && $past(rail_ok_i) && !rail_ok_i) |=> !takeover_o); // R6

    AST_ENABLES_TRACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_oe_o == takeover_o) && (keepalive_oe_o == takeover_o)); // R8
endmodule

bind warm_hold_override warm_hold_override_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hold_n_i      (hold_n_i),
    .rail_ok_i     (rail_ok_i),
    .cpu_rst_oe_o  (cpu_rst_oe_o),
    .keepalive_oe_o(keepalive_oe_o),
    .takeover_o    (takeover_o),
    .cold_req_o    (cold_req_o)
);

// File: tb/tb_warm_hold_override.sv
// Bench: scoreboard for warm_hold_override. The driver applies one step of
// stimulus per cycle and pushes the outputs expected after the next edge,
// computed from the requirements; the monitor pops and compares.
module tb_warm_hold_override;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_n_i = 1'b1;
    logic rail_ok_i = 1'b0;
    logic cpu_rst_oe_o, cpu_rst_lvl_o, keepalive_oe_o, keepalive_lvl_o;
    logic takeover_o, cold_req_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Expected outputs: {cpu_rst_oe, cpu_rst_lvl, keep_oe, keep_lvl, takeover, req}
    typedef struct {
        logic [5:0] vec;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    // Requirement-level model state
    logic m_hold_prev = 1'b1;
    logic m_rail_prev = 1'b0;
    logic m_flag = 1'b0;

    always #5 clk = ~clk;

    warm_hold_override dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .hold_n_i       (hold_n_i),
        .rail_ok_i      (rail_ok_i),
        .cpu_rst_oe_o   (cpu_rst_oe_o),
        .cpu_rst_lvl_o  (cpu_rst_lvl_o),
        .keepalive_oe_o (keepalive_oe_o),
        .keepalive_lvl_o(keepalive_lvl_o),
        .takeover_o     (takeover_o),
        .cold_req_o     (cold_req_o)
    );

    // Driver: apply inputs at the falling edge, push expected outputs
    task automatic step(input logic r, input logic h, input logic ok, input string tag);
        logic req;
        exp_t e;
        @(negedge clk);
        rst_n = r;
        hold_n_i = h;
        rail_ok_i = ok;
        req = 1'b0;
        if (!r) begin
            m_flag = 1'b0;
            m_hold_prev = 1'b1;
            m_rail_prev = 1'b0;
        end else begin
            req = m_flag && !m_hold_prev && h;           // R4, R5
            if (m_flag && m_rail_prev && !ok)            // R6
                m_flag = 1'b0;
            else if (m_hold_prev && !h && ok)            // R2, R9
                m_flag = 1'b1;
            m_hold_prev = h;
            m_rail_prev = ok;
        end
        e.vec = {m_flag, ~m_flag, m_flag, m_flag, m_flag, req}; // R8 levels
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                logic [5:0] act;
                e = exp_q.pop_front();
                act = {cpu_rst_oe_o, cpu_rst_lvl_o, keepalive_oe_o, keepalive_lvl_o,
                       takeover_o, cold_req_o};
                checks++;
                if (act !== e.vec) begin
                    failures++;
                    $display("FAIL %s actual=%b expected=%b", e.tag, act, e.vec);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset clears everything
        step(0, 1, 1, "R1");
        step(0, 1, 1, "R1");
        step(1, 1, 1, "R1");
        step(1, 1, 1, "R1");
        // R3: hold falls under dead rail, then rail rises during the hold
        step(1, 1, 0, "R7");
        step(1, 0, 0, "R3");
        step(1, 0, 0, "R3");
        step(1, 0, 1, "R3");
        step(1, 0, 1, "R3");
        // R5: release with no takeover
        step(1, 1, 1, "R5");
        step(1, 1, 1, "R5");
        // R2: takeover under a live rail
        step(1, 0, 1, "R2");
        step(1, 0, 1, "R2");
        step(1, 0, 1, "R2");
        // R4: release gives a one-cycle request, drives kept (R8)
        step(1, 1, 1, "R4");
        step(1, 1, 1, "R4");
        step(1, 1, 1, "R8");
        // Hold again during takeover: flag stays set
        step(1, 0, 1, "R2");
        step(1, 1, 1, "R4");
        // R6: rail collapse releases
        step(1, 1, 0, "R6");
        step(1, 1, 0, "R6");
        // R7: rail toggles with flag clear
        step(1, 1, 1, "R7");
        step(1, 1, 0, "R7");
        step(1, 1, 1, "R7");
        // R10: release and rail drop in the same cycle
        step(1, 0, 1, "R10");
        step(1, 0, 1, "R10");
        step(1, 1, 0, "R10");
        step(1, 1, 0, "R10");
        // R1: reset during a takeover clears it
        step(1, 1, 1, "R1");
        step(1, 0, 1, "R1");
        step(0, 0, 1, "R1");
        step(0, 0, 1, "R1");
        // R9: hold low when reset releases under a live rail
        step(1, 0, 1, "R9");
        step(1, 0, 1, "R9");
        step(1, 1, 1, "R9");
        step(1, 1, 1, "R9");
        step(1, 1, 0, "R6");
        step(1, 1, 0, "R6");
        // Drain
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule